// File: doc/BRIEF.md
# Clock Timing Generator Mode Controller

This block selects the operating mode of one clock timing generator. It also produces the signed fractional frequency offset word that steers a downstream synthesizer. There are four modes. In Synchronized mode the word follows the frequency measured by the locking loop. The three self-timing modes apply a fixed word instead:

- Holdover replays a long-term average of the locked frequency.
- Pseudo-Holdover replays a short-term average.
- Freerun applies a programmable calibration value that cancels the error of the local oscillator.

While the generator is Synchronized, the controller keeps both frequency averages up to date on each update tick. When the reference is lost, it falls back to the best history that is valid. It returns to Synchronized once the reference has been good for a programmed number of consecutive ticks. Software can load either history directly or clear both. A force input overrides the automatic choice.

Top module: `tg_mode_ctrl`

## Requirements
- R1: After reset the mode is Freerun, both history valid flags are low, and `ffo` equals `cal_offset`.
- R2: `ffo` selects its source from the current mode. Mode codes are 0 Freerun, 1 Synchronized, 2 Pseudo-Holdover, 3 Holdover. The sources are `cal_offset`, `loop_freq`, the short history and the long history, in that code order.
- R3: The controller enters Synchronized exactly when the reference has been valid for `lock_need` consecutive ticks. Any cycle with `ref_ok` low restarts the count.
- R4: Without a qualified reference, the mode is chosen as follows: Holdover if the long history is valid, otherwise Pseudo-Holdover if the short history is valid, otherwise Freerun.
- R5: On each tick in Synchronized mode, each history h is updated to h + ((loop_freq - h) >>> S). S is 4 for the short history and 10 for the long one. The first update after a clear loads `loop_freq` directly.
- R6: A history becomes valid once it has taken at least max(need, 1) updates. The need is `st_need` for the short history and `lt_need` for the long one.
- R7: Both histories hold their values in every mode other than Synchronized.
- R8: A pulse on `hist_wr` loads `hist_wdata` into the short history (`hist_sel`=0) or the long history (`hist_sel`=1). The loaded history becomes valid.
- R9: A pulse on `hist_clr` zeroes both histories and drops both valid flags.
- R10: While `force_en` is high, the mode takes the value of `force_mode` on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| tick | input | 1 | History and qualification update strobe |
| ref_ok | input | 1 | Selected reference is valid |
| loop_freq | input | W | Signed frequency word from the locking loop |
| cal_offset | input | W | Freerun calibration offset |
| lock_need | input | CW | Consecutive good ticks needed to synchronize |
| st_need | input | CW | Updates needed for a valid short history |
| lt_need | input | CW | Updates needed for a valid long history |
| force_en | input | 1 | Override automatic mode selection |
| force_mode | input | 2 | Mode applied while forced |
| hist_wr | input | 1 | Load a history from software |
| hist_sel | input | 1 | History chosen by hist_wr: 0 short, 1 long |
| hist_wdata | input | W | Value loaded by hist_wr |
| hist_clr | input | 1 | Clear both histories |
| st_hist | output | W | Short-term history value |
| lt_hist | output | W | Long-term history value |
| st_valid | output | 1 | Short history is valid |
| lt_valid | output | 1 | Long history is valid |
| mode | output | 2 | Current mode |
| ffo | output | W | Fractional frequency offset to the synthesizer |

## Verification
Each result has a fixed latency:

- History values, valid flags and clear or load effects appear one edge after the tick or pulse that causes them.
- A mode change caused by a tick lands one edge later, because the qualification count is registered before the mode.
- A change in `ref_ok` or `force_en` moves the mode on the very next edge.
- `ffo` follows the mode in the same cycle.

The bench drives every stimulus just after a falling edge and counts edges explicitly before sampling at a falling edge. When it sweeps `lock_need`, it confirms that Synchronized mode is absent after every tick but the last qualifying one.

// File: rtl/tg_mode_ctrl.sv
module tg_mode_ctrl #(
  parameter int W     = 32,
  parameter int CW    = 8,
  parameter int ST_SH = 4,
  parameter int LT_SH = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          ref_ok,
  input  logic [W-1:0]  loop_freq,
  input  logic [W-1:0]  cal_offset,
  input  logic [CW-1:0] lock_need,
  input  logic [CW-1:0] st_need,
  input  logic [CW-1:0] lt_need,
  input  logic          force_en,
  input  logic [1:0]    force_mode,
  input  logic          hist_wr,
  input  logic          hist_sel,
  input  logic [W-1:0]  hist_wdata,
  input  logic          hist_clr,
  output logic [W-1:0]  st_hist,
  output logic [W-1:0]  lt_hist,
  output logic          st_valid,
  output logic          lt_valid,
  output logic [1:0]    mode,
  output logic [W-1:0]  ffo
);
  localparam logic [1:0] M_FREE = 2'd0, M_SYNC = 2'd1, M_PSEUDO = 2'd2, M_HOLD = 2'd3;
  localparam logic [CW-1:0] CMAX = {CW{1'b1}};

  logic [CW-1:0] ref_cnt, st_cnt, lt_cnt;
  logic signed [W:0] st_diff, lt_diff;
  logic [W-1:0] st_next, lt_next;

  wire qualified = ref_ok && (ref_cnt >= lock_need);
  wire upd = tick && (mode == M_SYNC);
  wire [1:0] fallback = lt_valid ? M_HOLD : (st_valid ? M_PSEUDO : M_FREE);
  wire [1:0] auto_mode = qualified ? M_SYNC : fallback;

  assign st_valid = (st_cnt != '0) && (st_cnt >= st_need);
  assign lt_valid = (lt_cnt != '0) && (lt_cnt >= lt_need);

  assign st_diff = $signed({loop_freq[W-1], loop_freq}) - $signed({st_hist[W-1], st_hist});
  assign lt_diff = $signed({loop_freq[W-1], loop_freq}) - $signed({lt_hist[W-1], lt_hist});
  assign st_next = (st_cnt == '0) ? loop_freq : st_hist + W'(st_diff >>> ST_SH);
  assign lt_next = (lt_cnt == '0) ? loop_freq : lt_hist + W'(lt_diff >>> LT_SH);

  always_comb begin
    case (mode)
      M_SYNC:   ffo = loop_freq;
      M_PSEUDO: ffo = st_hist;
      M_HOLD:   ffo = lt_hist;
      default:  ffo = cal_offset;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_cnt <= '0;
      mode    <= M_FREE;
    end else begin
      if (!ref_ok) ref_cnt <= '0;
      else if (tick && ref_cnt < lock_need) ref_cnt <= ref_cnt + 1'b1;
      mode <= force_en ? force_mode : auto_mode;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_hist <= '0; lt_hist <= '0; st_cnt <= '0; lt_cnt <= '0;
    end else if (hist_clr) begin
      st_hist <= '0; lt_hist <= '0; st_cnt <= '0; lt_cnt <= '0;
    end else if (hist_wr) begin
      if (hist_sel) begin lt_hist <= hist_wdata; lt_cnt <= CMAX; end
      else          begin st_hist <= hist_wdata; st_cnt <= CMAX; end
    end else if (upd) begin
      st_hist <= st_next;
      lt_hist <= lt_next;
      if (st_cnt != CMAX) st_cnt <= st_cnt + 1'b1;
      if (lt_cnt != CMAX) lt_cnt <= lt_cnt + 1'b1;
    end
  end

  // R3
  sync_needs_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_SYNC && !$past(force_en)) |-> $past(ref_ok));
  // R4
  holdover_needs_lt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_HOLD && !$past(force_en)) |-> $past(lt_valid));
  // R7
  history_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != M_SYNC && !hist_wr && !hist_clr) |=> ($stable(lt_hist) && $stable(st_hist)));
  // R9
  clear_drops_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hist_clr |=> (!st_valid && !lt_valid));
  // R10
  force_applies_chk: assert property (@(posedge clk) disable iff (!rst_n)
    force_en |=> (mode == $past(force_mode)));
endmodule

// File: tb/tg_mode_ctrl_test.sv
module tg_mode_ctrl_test;
  logic clk = 0, rst_n = 0, tick = 0, ref_ok = 0, force_en = 0, hist_wr = 0, hist_sel = 0, hist_clr = 0;
  logic [31:0] loop_freq = 0, cal_offset = 32'h0000_1234, hist_wdata = 0;
  logic [7:0] lock_need = 1, st_need = 2, lt_need = 3;
  logic [1:0] force_mode = 0;
  logic [31:0] st_hist, lt_hist, ffo;
  logic st_valid, lt_valid;
  logic [1:0] mode;
  int checks = 0, errors = 0;
  bit done = 0;
  int st_m, lt_m, st_n, lt_n;

  tg_mode_ctrl uut (.*);

  always #2 clk = ~clk;

  task automatic chk(input string r, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d", r, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic tk();
    tick = 1; @(negedge clk); tick = 0;
  endtask

  task automatic clr();
    hist_clr = 1; @(negedge clk); hist_clr = 0;
    st_m = 0; lt_m = 0; st_n = 0; lt_n = 0;
  endtask

  task automatic model_upd(input int f);
    longint d;
    if (st_n == 0) st_m = f; else begin d = longint'(f) - longint'(st_m); st_m = int'(longint'(st_m) + (d >>> 4)); end
    if (lt_n == 0) lt_m = f; else begin d = longint'(f) - longint'(lt_m); lt_m = int'(longint'(lt_m) + (d >>> 10)); end
    st_n++; lt_n++;
  endtask

  initial begin
    int vals[6];
    vals = '{32'sd1000000, -32'sd5000000, 32'sd123456789, -32'sd2000000000, 32'sd77, 32'sd2147483000};
    step(2);
    // R1 reset values
    chk("R1 mode", mode, 0);
    chk("R1 valid", {st_valid, lt_valid}, 0);
    chk("R1 ffo", ffo, 32'h1234);
    rst_n = 1; step(1);

    // R3 sweep of lock_need: sync only after the last qualifying tick
    for (int n = 1; n <= 4; n++) begin
      ref_ok = 0; clr(); step(1);
      lock_need = n[7:0]; ref_ok = 1; step(1);
      for (int k = 1; k <= n; k++) begin
        tk(); step(1);
        chk("R3 sync after ticks", mode, (k == n) ? 1 : 0);
      end
    end

    // R3 a ref drop restarts the count
    ref_ok = 0; clr(); step(2);
    lock_need = 3; ref_ok = 1; tk(); tk();
    ref_ok = 0; step(1); ref_ok = 1; tk(); tk(); step(1);
    chk("R3 restart", mode, 0);
    tk(); step(1);
    chk("R3 requalify", mode, 1);

    // R5/R6 history averaging and validity, R2 sync source
    clr(); st_need = 2; lt_need = 3;
    for (int i = 0; i < 6; i++) begin
      loop_freq = vals[i]; tk(); model_upd(vals[i]);
      chk("R5 short hist", $signed(st_hist), st_m);
      chk("R5 long hist", $signed(lt_hist), lt_m);
      chk("R6 short valid", st_valid, st_n >= 2);
      chk("R6 long valid", lt_valid, lt_n >= 3);
      chk("R2 sync ffo", ffo, loop_freq);
    end

    // R4 loss with long history valid -> holdover, R2 holdover source
    ref_ok = 0; step(2);
    chk("R4 holdover", mode, 3);
    chk("R2 holdover ffo", $signed(ffo), lt_m);
    // R7 histories frozen outside sync
    loop_freq = 32'h0555_0000; tk(); tk(); tk();
    chk("R7 long frozen", $signed(lt_hist), lt_m);
    chk("R7 short frozen", $signed(st_hist), st_m);

    // R4 loss with only short history valid -> pseudo-holdover
    clr(); st_need = 1; lt_need = 5; lock_need = 1; ref_ok = 1;
    tk(); step(1);
    chk("R3 resync", mode, 1);
    loop_freq = 32'd4242; tk(); tk(); model_upd(4242); model_upd(4242);
    ref_ok = 0; step(2);
    chk("R4 pseudo", mode, 2);
    chk("R2 pseudo ffo", $signed(ffo), st_m);
    chk("R6 long not yet", lt_valid, 0);

    // R9 clear -> freerun
    clr(); step(1);
    chk("R9 valid", {st_valid, lt_valid}, 0);
    chk("R9 hist", {st_hist, lt_hist}, 0);
    chk("R4 freerun", mode, 0);
    chk("R2 freerun ffo", ffo, 32'h1234);

    // R8 software load
    hist_sel = 0; hist_wdata = 32'hFFFF_FF00; hist_wr = 1; step(1); hist_wr = 0;
    chk("R8 short loaded", st_hist, 32'hFFFF_FF00);
    chk("R8 short valid", st_valid, 1);
    step(1);
    chk("R8 pseudo", mode, 2);
    hist_sel = 1; hist_wdata = 32'h0000_0ABC; hist_wr = 1; step(1); hist_wr = 0;
    chk("R8 long loaded", lt_hist, 32'h0000_0ABC);
    step(1);
    chk("R8 holdover", mode, 3);

    // R10 force override
    for (int m = 0; m < 4; m++) begin
      force_mode = m[1:0]; force_en = 1; step(1);
      chk("R10 forced", mode, m);
    end
    force_en = 0; step(1);
    chk("R10 release", mode, 3);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog act=0 exp=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule